// File: doc/BRIEF.md
# Daisy-Chain Serial Output Controller

This block takes on/off commands for a set of output channels over a three-wire serial link. A serial clock, a data line and a latch strobe all arrive without a fixed relation to the system clock. Each serial-clock rising edge moves one bit into a holding register. The bit pushed out of the far end of that register appears on a serial data output, so several controllers can sit on one link, each feeding the next.

A latch rising edge copies the holding register into a separate output register. New commands can therefore be shifted in while the channels keep their current state. Each channel's on signal is the AND of three things: its output-register bit, a low active-low enable, and a per-channel drive permit from a fault sequencer. The enable only gates the channel outputs. Shifting and latching carry on while it is high.

The serial clock, data and latch inputs pass through two-flop synchronizers. Their rising edges are detected in the system clock domain. A synchronous active-high reset clears both register stages. The same reset input is meant to carry power-up and undervoltage reset.

Top module: `chain_driver_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, all bits of `chan_on` are 0 and `ser_dout` is 0. Both the holding register and the output register are cleared.
- R2: Each rising edge of `ser_clk` shifts the sampled `ser_din` into holding stage 0, and stage k moves to stage k+1. After four shifts the first bit sent sits in stage 3, which drives channel index 3 (`chan_on[3]`). The last bit sent drives `chan_on[0]`.
- R3: `ser_dout` carries the content of the last holding stage. After four shifts into a cleared register it equals the first bit sent, and after a fifth shift it equals the second bit sent.
- R4: While `latch_strb` shows no rising edge, shifting changes neither the output register nor `chan_on`.
- R5: Only a rising edge of `latch_strb` copies the holding register into the output register. Holding `latch_strb` high while more bits are shifted does not copy again.
- R6: `chan_on[i]` is 1 only when output-register bit i is 1, `en_n` is 0 and `permit[i]` is 1. `chan_on` is registered and follows a change of `en_n` or `permit` one system clock later.
- R7: A high `en_n` forces every `chan_on` bit to 0 but does not stop shifting, `ser_dout` or latching. A pattern loaded while `en_n` is high appears once `en_n` goes low.
- R8: A `rst` pulse in the middle of operation clears both stages. A later latch with no new shifts leaves all `chan_on` bits at 0.
- R9: A level on `ser_clk` held high over many system clocks counts as one shift only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up and undervoltage) |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in, sampled at the serial-clock rising edge |
| latch_strb | input | 1 | Latch strobe, rising edge copies holding to output register |
| en_n | input | 1 | Active-low channel enable |
| permit | input | NCH | Per-channel drive permit from the fault sequencer |
| ser_dout | output | 1 | Bit from the last holding stage, for the next device in the chain |
| chan_on | output | NCH | Channel on controls |

## Verification
The assertions check the following on every cycle:
- The shift step from each stage to the next on a detected serial edge.
- That `ser_dout` takes the old next-to-last stage.
- That the output register holds between latch edges and takes the prior holding contents on a latch edge.
- That no channel is on the cycle after `en_n` was high or its permit was low.
- That the state is cleared after reset.

The bench scenarios show the end-to-end bit order from the serial line to the channel index. They also cover the single-shift response to a long clock level, the lack of re-latching on a held strobe, shifting while disabled, and the cleared state after a mid-run reset.

// File: rtl/chain_drv_pkg.sv
package chain_drv_pkg;
  localparam int unsigned DEF_NCH   = 4;
  localparam int unsigned DEF_SYNC  = 2;
  localparam int unsigned SYNC_BITS = 3;
  localparam int unsigned IDX_DIN   = 0;
  localparam int unsigned IDX_SCLK  = 1;
  localparam int unsigned IDX_LATCH = 2;
endpackage

// File: rtl/chain_sync_bank.sv
module chain_sync_bank #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/chain_rise_det.sv
module chain_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign pulse = lvl & ~prev_q;
endmodule

// File: rtl/chain_hold_reg.sv
module chain_hold_reg #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [NCH-1:0] hold_q,
  output logic           dout
);
  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (shift_en) hold_q <= {hold_q[NCH-2:0], din};
  end

  // last stage is a flop, so the chain output is registered
  assign dout = hold_q[NCH-1];
endmodule

// File: rtl/chain_out_stage.sv
module chain_out_stage #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [NCH-1:0] hold_d,
  input  logic           en_n,
  input  logic [NCH-1:0] permit,
  output logic [NCH-1:0] out_q,
  output logic [NCH-1:0] chan_on
);
  always_ff @(posedge clk) begin
    if (rst)       out_q <= '0;
    else if (load) out_q <= hold_d;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_gate
      always_ff @(posedge clk) begin
        if (rst) chan_on[i] <= 1'b0;
        else     chan_on[i] <= out_q[i] & ~en_n & permit[i];
      end
    end
  endgenerate
endmodule

// File: rtl/chain_driver_ctrl.sv
module chain_driver_ctrl
  import chain_drv_pkg::*;
#(
  parameter int unsigned NCH         = DEF_NCH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           latch_strb,
  input  logic           en_n,
  input  logic [NCH-1:0] permit,
  output logic           ser_dout,
  output logic [NCH-1:0] chan_on
);
  logic [SYNC_BITS-1:0] raw_in;
  logic [SYNC_BITS-1:0] syn_in;
  logic                 sclk_edge;
  logic                 latch_edge;
  logic [NCH-1:0]       hold_q;
  logic [NCH-1:0]       out_q;

  always_comb begin
    raw_in            = '0;
    raw_in[IDX_DIN]   = ser_din;
    raw_in[IDX_SCLK]  = ser_clk;
    raw_in[IDX_LATCH] = latch_strb;
  end

  // data goes through the same depth as the clock, keeping them aligned
  chain_sync_bank #(.W(SYNC_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  chain_rise_det u_sclk_det (
    .clk   (clk),
    .rst   (rst),
    .lvl   (syn_in[IDX_SCLK]),
    .pulse (sclk_edge)
  );

  chain_rise_det u_latch_det (
    .clk   (clk),
    .rst   (rst),
    .lvl   (syn_in[IDX_LATCH]),
    .pulse (latch_edge)
  );

  chain_hold_reg #(.NCH(NCH)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_edge),
    .din      (syn_in[IDX_DIN]),
    .hold_q   (hold_q),
    .dout     (ser_dout)
  );

  chain_out_stage #(.NCH(NCH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (latch_edge),
    .hold_d  (hold_q),
    .en_n    (en_n),
    .permit  (permit),
    .out_q   (out_q),
    .chan_on (chan_on)
  );
endmodule

// File: rtl/chain_driver_ctrl_chk.sv
module chain_driver_ctrl_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en_n,
  input logic [NCH-1:0] permit,
  input logic [NCH-1:0] chan_on,
  input logic           ser_dout,
  input logic [NCH-1:0] hold_q,
  input logic [NCH-1:0] out_q,
  input logic           sclk_edge,
  input logic           latch_edge
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: state is cleared in the cycle after a reset cycle
  always @(posedge clk) begin
    if (rst_seen) begin
      p_reset_clear_r1: assert (hold_q == '0 && out_q == '0 && chan_on == '0 && !ser_dout)
        else $error("p_reset_clear_r1");
    end
  end

  p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
    sclk_edge |=> (hold_q[NCH-1:1] == $past(hold_q[NCH-2:0])));

  p_chain_out_r3: assert property (@(posedge clk) disable iff (rst)
    sclk_edge |=> (ser_dout == $past(hold_q[NCH-2])));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !latch_edge |=> $stable(out_q));

  p_latch_copy_r5: assert property (@(posedge clk) disable iff (rst)
    latch_edge |=> (out_q == $past(hold_q)));

  p_enable_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $past(en_n) |-> (chan_on == '0));

  p_permit_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (chan_on & ~$past(permit)) == '0);

  p_no_shift_r9: assert property (@(posedge clk) disable iff (rst)
    !sclk_edge |=> $stable(hold_q));
endmodule

bind chain_driver_ctrl chain_driver_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_n       (en_n),
  .permit     (permit),
  .chan_on    (chan_on),
  .ser_dout   (ser_dout),
  .hold_q     (hold_q),
  .out_q      (out_q),
  .sclk_edge  (sclk_edge),
  .latch_edge (latch_edge)
);

// File: tb/tb_chain_driver_ctrl.sv
`timescale 1ns/1ps
module tb_chain_driver_ctrl;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ser_clk = 1'b0;
  logic           ser_din = 1'b0;
  logic           latch_strb = 1'b0;
  logic           en_n = 1'b0;
  logic [NCH-1:0] permit = '1;
  logic           ser_dout;
  logic [NCH-1:0] chan_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chain_driver_ctrl #(.NCH(NCH)) dut (
    .clk        (clk),
    .rst        (rst),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .latch_strb (latch_strb),
    .en_n       (en_n),
    .permit     (permit),
    .ser_dout   (ser_dout),
    .chan_on    (chan_on)
  );

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input int high_len = 4);
    ser_din = b;
    wait_clk(3);
    ser_clk = 1'b1;
    wait_clk(high_len);
    ser_clk = 1'b0;
    wait_clk(4);
  endtask

  // first bit sent ends in stage 3, so send from index 3 down
  task automatic shift_word(input logic [NCH-1:0] w);
    for (int i = NCH - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic latch_pulse();
    latch_strb = 1'b1;
    wait_clk(4);
    latch_strb = 1'b0;
    wait_clk(6);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(1);
  endtask

  task automatic t_reset_state();
    wait_clk(3);
    chk("R1 chan_on in reset", chan_on, '0);
    chk("R1 ser_dout in reset", {3'b0, ser_dout}, '0);
    rst = 1'b0;
    wait_clk(1);
    chk("R1 chan_on after reset", chan_on, '0);
  endtask

  task automatic t_bit_order();
    shift_word(4'b1000);
    chk("R4 no latch yet", chan_on, '0);
    latch_pulse();
    chk("R2 first bit to chan 3", chan_on, 4'b1000);
    shift_word(4'b0110);
    chk("R4 shift keeps outputs", chan_on, 4'b1000);
    latch_pulse();
    chk("R2 pattern 0110", chan_on, 4'b0110);
  endtask

  task automatic t_chain_out();
    do_reset();
    shift_word(4'b1011);
    chk("R3 dout after four shifts", {3'b0, ser_dout}, 4'b0001);
    shift_bit(1'b1);
    chk("R3 dout after fifth shift", {3'b0, ser_dout}, 4'b0000);
    shift_bit(1'b0);
    chk("R3 dout after sixth shift", {3'b0, ser_dout}, 4'b0001);
  endtask

  task automatic t_long_clock();
    do_reset();
    shift_word(4'b0000);
    shift_bit(1'b1, 40);
    latch_pulse();
    chk("R9 long high is one shift", chan_on, 4'b0001);
  endtask

  task automatic t_enable_and_permit();
    do_reset();
    shift_word(4'b1111);
    latch_pulse();
    chk("R6 all on", chan_on, 4'b1111);
    permit = 4'b0101;
    wait_clk(2);
    chk("R6 permit gating", chan_on, 4'b0101);
    permit = '1;
    en_n = 1'b1;
    wait_clk(2);
    chk("R6 enable gating", chan_on, '0);
    shift_word(4'b1001);
    chk("R7 dout moves while disabled", {3'b0, ser_dout}, 4'b0001);
    latch_pulse();
    chk("R7 still off while disabled", chan_on, '0);
    en_n = 1'b0;
    wait_clk(2);
    chk("R7 latched while disabled", chan_on, 4'b1001);
  endtask

  task automatic t_held_latch();
    do_reset();
    shift_word(4'b0011);
    latch_strb = 1'b1;
    wait_clk(6);
    chk("R5 latch edge copies", chan_on, 4'b0011);
    shift_word(4'b1100);
    chk("R5 held latch no recopy", chan_on, 4'b0011);
    latch_strb = 1'b0;
    wait_clk(4);
    latch_pulse();
    chk("R5 next edge copies", chan_on, 4'b1100);
  endtask

  task automatic t_mid_reset();
    shift_word(4'b1011);
    latch_pulse();
    chk("R8 loaded before reset", chan_on, 4'b1011);
    do_reset();
    chk("R8 outputs cleared", chan_on, '0);
    chk("R8 dout cleared", {3'b0, ser_dout}, '0);
    latch_pulse();
    chk("R8 holding cleared", chan_on, '0);
  endtask

  initial begin
    t_reset_state();
    t_bit_order();
    t_chain_out();
    t_long_clock();
    t_enable_and_permit();
    t_held_latch();
    t_mid_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule